// File: doc/BRIEF.md
# Clock-Loss Watchdog with Restart Synchronizer

This block watches for a main system clock that has stopped. It counts on a separate reference clock, one that does not come from the supervised clock. If the counter reaches a fixed terminal count before a restart arrives, the block flags expiry. The restart comes from the system-clock domain as a single-cycle strobe. That strobe is raised by any write to a designated timer control register, and the written data is never looked at. Normal software watchdog servicing therefore also keeps this block quiet, with no extra software action.

The strobe is turned into a level toggle in the system domain. The toggle crosses into the reference domain through a chain of synchronizer flops, and is edge-detected there to form a restart pulse. The expiry flag is merged with the status of the regular software watchdog, which arrives as an input. The merged result drives a single active-low, open-drain style output. The output pulls low when either watchdog has expired and is released to high impedance otherwise. The terminal count is fixed at build time, and no state is readable.

Top module: `clkloss_wdog`

## Requirements
- R1: While `ref_rst_n` is low at a reference clock edge, the counter returns to zero and the expiry flag clears. With `swdog_expired` low, `wdog_low_en` is then 0 and `wdog_n` is released.
- R2: After reset release or after a restart, with no further restart, `wdog_low_en` (with `swdog_expired` low) stays 0 for the first TIMEOUT-1 rising `ref_clk` edges. It becomes 1 at the TIMEOUT-th edge. The default TIMEOUT is 100,000,000.
- R3: Once expired, the counter stops at TIMEOUT without wrapping. The expiry indication stays set for any number of reference cycles until a restart.
- R4: A `kick_wr` pulse one `sys_clk` cycle wide restarts the counter and clears the expiry. This takes effect within one system cycle plus SYNC_STAGES+2 reference cycles.
- R5: Restarts issued more often than every TIMEOUT reference cycles keep `wdog_low_en` at 0 indefinitely.
- R6: `wdog_low_en` is 1 exactly when the clock-loss watchdog has expired or `swdog_expired` is 1. `wdog_n` is driven 0 while `wdog_low_en` is 1, and is high impedance otherwise.
- R7: `swdog_expired` has no effect on the clock-loss counter. Raising and then lowering it before expiry returns `wdog_low_en` to 0 at once.
- R8: The counter advances on `ref_clk` alone. With `sys_clk` stopped and no restart, expiry is still flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Supervised system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| kick_wr | input | 1 | Single-cycle restart strobe (register write seen) |
| ref_clk | input | 1 | Independent reference clock |
| ref_rst_n | input | 1 | Synchronous active-low reset, reference domain |
| swdog_expired | input | 1 | Expiry status of the regular software watchdog |
| wdog_low_en | output | 1 | Output enable: 1 pulls the watchdog line low |
| wdog_n | output | 1 | Active-low open-drain style watchdog line (0 or Z) |

## Verification
The assertions check the counter on every reference cycle. They confirm that it steps by one, that it never passes the terminal value, and that expiry rises only from TIMEOUT-1. They also confirm that expiry stays set until a restart pulse, that a restart pulse clears the state, and that every strobe flips the system-side toggle. The end-to-end behaviour needs the bench scenarios. These cover the exact expiry edge after reset, strobes crossing between unrelated clock phases, and periodic kicking that holds the output off. They also cover expiry with the system clock stopped and the merge with the software watchdog input.

// File: rtl/clkloss_wdog_pkg.sv
// Package: shared defaults and width helper for the clock-loss watchdog.
// Assumes TIMEOUT fits in 32 bits.
package clkloss_wdog_pkg;
    localparam int unsigned DEFAULT_TIMEOUT = 100_000_000;
    localparam int unsigned DEFAULT_SYNC    = 2;

    // Counter width able to hold the value TIMEOUT itself.
    function automatic int unsigned cnt_width(input int unsigned t);
        return $clog2(t + 1);
    endfunction
endpackage

// File: rtl/clkloss_kick_tx.sv
// System-domain side of the restart crossing: every strobe flips a level.
// Assumes kick_wr is synchronous to sys_clk and is one cycle per write.
module clkloss_kick_tx (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic kick_wr,
    output logic kick_tgl
);
    // Flip the toggle on each strobe; clear on reset.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n)   kick_tgl <= 1'b0;
        else if (kick_wr) kick_tgl <= ~kick_tgl;
    end
endmodule

// File: rtl/clkloss_kick_rx.sv
// Reference-domain side of the restart crossing. It runs the toggle through
// STAGES synchronizer flops and emits a one-cycle pulse on each change.
// Assumes both domain resets are applied together, so the toggle and the
// synchronizer start from the same value.
module clkloss_kick_rx #(
    parameter int unsigned STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic kick_tgl,
    output logic kick_ref
);
    logic [STAGES-1:0] sync_q;
    logic              seen_q;

    // First synchronizer stage samples the asynchronous toggle.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) sync_q[0] <= 1'b0;
        else            sync_q[0] <= kick_tgl;
    end

    // Remaining synchronizer stages.
    for (genvar i = 1; i < STAGES; i++) begin : g_sync
        always_ff @(posedge ref_clk) begin
            if (!ref_rst_n) sync_q[i] <= 1'b0;
            else            sync_q[i] <= sync_q[i-1];
        end
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) seen_q <= 1'b0;
        else            seen_q <= sync_q[STAGES-1];
    end

    // Either edge of the synchronized toggle is one restart.
    always_comb kick_ref = sync_q[STAGES-1] ^ seen_q;
endmodule

// File: rtl/clkloss_timer.sv
// Fixed-timeout counter on the reference clock. It counts up from zero and
// sets a sticky expiry flag at TIMEOUT. It then stops, and holds until a
// restart pulse or reset. Assumes TIMEOUT >= 2.
module clkloss_timer #(
    parameter int unsigned TIMEOUT = 100_000_000,
    parameter int unsigned CNT_W   = 27
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic             kick_ref,
    output logic [CNT_W-1:0] cnt,
    output logic             expired
);
    localparam logic [CNT_W-1:0] LAST_BEFORE = CNT_W'(TIMEOUT - 1);

    // Count, saturate at the terminal value, and restart on a kick.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n || kick_ref) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BEFORE) expired <= 1'b1;
        end
    end
endmodule

// File: rtl/clkloss_wdog.sv
// Top level: restart crossing, clock-loss timer and output merge.
// Assumes sys_rst_n and ref_rst_n are asserted together, and that kicks are
// spaced more than SYNC_STAGES+2 reference cycles apart.
module clkloss_wdog
    import clkloss_wdog_pkg::*;
#(
    parameter  int unsigned TIMEOUT     = DEFAULT_TIMEOUT,
    parameter  int unsigned SYNC_STAGES = DEFAULT_SYNC,
    localparam int unsigned CNT_W       = cnt_width(TIMEOUT)
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic kick_wr,
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic swdog_expired,
    output logic wdog_low_en,
    output wire  wdog_n
);
    logic             kick_tgl;
    logic             kick_ref;
    logic [CNT_W-1:0] wd_cnt;
    logic             wd_expired;

    clkloss_kick_tx u_tx (
        .sys_clk  (sys_clk),
        .sys_rst_n(sys_rst_n),
        .kick_wr  (kick_wr),
        .kick_tgl (kick_tgl)
    );

    clkloss_kick_rx #(.STAGES(SYNC_STAGES)) u_rx (
        .ref_clk  (ref_clk),
        .ref_rst_n(ref_rst_n),
        .kick_tgl (kick_tgl),
        .kick_ref (kick_ref)
    );

    clkloss_timer #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_timer (
        .ref_clk  (ref_clk),
        .ref_rst_n(ref_rst_n),
        .kick_ref (kick_ref),
        .cnt      (wd_cnt),
        .expired  (wd_expired)
    );

    // Either watchdog expiring pulls the shared line low.
    always_comb wdog_low_en = wd_expired | swdog_expired;

    // Open-drain style pad model: drive zero or release.
    assign wdog_n = wdog_low_en ? 1'b0 : 1'bz;
endmodule

// File: rtl/clkloss_wdog_chk.sv
// Checker: timing properties of the clock-loss watchdog, bound to the top.
module clkloss_wdog_chk #(
    parameter int unsigned TIMEOUT = 100_000_000,
    parameter int unsigned CNT_W   = 27
) (
    input logic             sys_clk,
    input logic             sys_rst_n,
    input logic             kick_wr,
    input logic             kick_tgl,
    input logic             ref_clk,
    input logic             ref_rst_n,
    input logic             kick_ref,
    input logic [CNT_W-1:0] wd_cnt,
    input logic             wd_expired
);
    AST_NO_OVERFLOW: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        wd_cnt <= CNT_W'(TIMEOUT)); // R3
    AST_EXPIRY_STICKY: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (wd_expired && !kick_ref) |=> (wd_expired && $stable(wd_cnt))); // R3
    AST_COUNT_STEP: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (!wd_expired && !kick_ref) |=> (wd_cnt == CNT_W'($past(wd_cnt) + 1'b1))); // R2
    AST_EXPIRE_AT_TERMINAL: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(wd_expired) |-> ($past(wd_cnt) == CNT_W'(TIMEOUT - 1))); // R2
    AST_KICK_CLEARS: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        kick_ref |=> (!wd_expired && wd_cnt == '0)); // R4
    AST_STROBE_TOGGLES: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        kick_wr |=> (kick_tgl != $past(kick_tgl))); // R4
endmodule

bind clkloss_wdog clkloss_wdog_chk #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .kick_wr   (kick_wr),
    .kick_tgl  (kick_tgl),
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .kick_ref  (kick_ref),
    .wd_cnt    (wd_cnt),
    .wd_expired(wd_expired)
);

// File: tb/clkloss_wdog_bench.sv
// Bench: a vector table walked by one loop, then directed corner cases.
module clkloss_wdog_bench;
    localparam int unsigned T = 20;

    typedef struct packed {
        logic       swdog;
        logic [7:0] idle;
        logic       exp_oe;
    } vec_t;

    // After a restart: apply swdog, wait idle reference cycles, expect enable.
    localparam vec_t VECS [4] = '{
        '{swdog: 1'b0, idle: 8'd3,  exp_oe: 1'b0},
        '{swdog: 1'b1, idle: 8'd3,  exp_oe: 1'b1},
        '{swdog: 1'b0, idle: 8'd25, exp_oe: 1'b1},
        '{swdog: 1'b1, idle: 8'd25, exp_oe: 1'b1}
    };

    logic raw_sys = 1'b0, sys_run = 1'b1, ref_clk = 1'b0;
    logic sys_clk;
    logic sys_rst_n = 1'b0, ref_rst_n = 1'b0, kick_wr = 1'b0, swdog = 1'b0;
    logic wdog_low_en;
    wire  wdog_n;
    int   n_chk = 0, n_fail = 0;

    always #5 raw_sys = ~raw_sys;
    always #7 ref_clk = ~ref_clk;
    assign sys_clk = raw_sys & sys_run;

    clkloss_wdog #(.TIMEOUT(T)) u_clkloss_wdog (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .kick_wr(kick_wr),
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .swdog_expired(swdog),
        .wdog_low_en(wdog_low_en), .wdog_n(wdog_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ref_wait(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic kick();
        @(negedge raw_sys) kick_wr = 1'b1;
        @(negedge raw_sys) kick_wr = 1'b0;
        ref_wait(6);
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        sys_rst_n = 1'b0; ref_rst_n = 1'b0;
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk);
        sys_rst_n = 1'b1; ref_rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: state while reset is held
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R1 enable in reset", wdog_low_en, 1'b0);
        sys_rst_n = 1'b1; ref_rst_n = 1'b1;

        // R2: exact expiry edge after reset release
        ref_wait(T - 1);
        chk("R2 not yet expired at T-1", wdog_low_en, 1'b0);
        ref_wait(1);
        chk("R2 expired at T", wdog_low_en, 1'b1);
        chk("R6 line driven low", wdog_n, 1'b0);

        // R3: stays expired, no wrap
        ref_wait(3 * T + 7);
        chk("R3 still expired", wdog_low_en, 1'b1);

        // R4: single-cycle strobe restarts
        kick();
        chk("R4 kick clears expiry", wdog_low_en, 1'b0);

        // Vector table (R6 merge, R2 timeout after restart)
        foreach (VECS[i]) begin
            swdog = 1'b0;
            kick();
            swdog = VECS[i].swdog;
            ref_wait(int'(VECS[i].idle));
            chk("R6 vector merge", wdog_low_en, VECS[i].exp_oe);
        end
        swdog = 1'b0;

        // R5: periodic kicks keep it quiet
        kick();
        for (int k = 0; k < 8; k++) begin
            ref_wait(6);
            kick();
            chk("R5 periodic kick", wdog_low_en, 1'b0);
        end

        // R7: software watchdog input does not touch the counter
        kick();
        swdog = 1'b1;
        ref_wait(2);
        chk("R7 swdog drives enable", wdog_low_en, 1'b1);
        swdog = 1'b0;
        #1;
        chk("R7 swdog released", wdog_low_en, 1'b0);

        // R8: system clock stopped, reference still counts
        kick();
        sys_run = 1'b0;
        ref_wait(4);
        chk("R8 quiet early with sys clock stopped", wdog_low_en, 1'b0);
        ref_wait(T + 5);
        chk("R8 expiry with sys clock stopped", wdog_low_en, 1'b1);
        sys_run = 1'b1;

        // R1: reset while expired clears it
        do_reset();
        chk("R1 reset clears expiry", wdog_low_en, 1'b0);
        ref_wait(T);
        chk("R2 expiry after second reset", wdog_low_en, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule